// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

A synchronous two-port memory whose left and right ports each have a chip select, a write strobe, an output enable, an address, per-byte lane enables and separate write and read data buses. Both ports run on one clock and can access any word in the same cycle. Reads are registered: the word addressed in one cycle appears on the read bus after that clock edge and stays there until the port reads again.

The two highest word locations double as mailboxes between the ports. When the left port writes the top word, the right port's interrupt output goes active. When the right port writes the word just below the top, the left port's interrupt goes active. Each interrupt is cleared when the receiving port reads the mailbox that raised it. The mailbox words keep their data, so that read also returns the message.

Depth and data width are parameters. The data width is a multiple of eight. The address width is the base-2 logarithm of the depth.

Top module: `dpram_mailbox`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both interrupt outputs are high (inactive) and both read data registers hold zero.
- R2: A read cycle (cs=1, we=0) loads the addressed word into that port's read register at the clock edge. The word is visible on the read bus right after that edge, and the register changes only on the port's next read cycle.
- R3: Lane b covers data bits 8b+7 down to 8b. A write changes only the lanes whose enable bit is 1. A read returns zero in every lane whose enable bit is 0.
- R4: While oe is 0, the port's read bus is all zeros. Raising oe shows the value already held in the read register, with no new read cycle.
- R5: A left write cycle (cs=1, we=1) to address DEPTH-1 drives r_int_n low after that clock edge.
- R6: A right read cycle of address DEPTH-1 drives r_int_n high after the edge and returns the stored mailbox word.
- R7: A right write cycle to address DEPTH-2 drives l_int_n low after that clock edge.
- R8: A left read cycle of address DEPTH-2 drives l_int_n high after the edge and returns the stored mailbox word.
- R9: If a flag is set and cleared in the same cycle, the set wins and the interrupt stays or becomes low.
- R10: When both ports write the same address in one cycle, each lane enabled on both ports takes the left port's data. A lane enabled on only one port takes that port's data.
- R11: A read of an address that the other port writes in the same cycle returns the word as it was before that write.
- R12: Only the accesses listed in R5 to R8 change an interrupt. For example, the left port reading DEPTH-1 or the right port reading DEPTH-2 leaves both interrupts as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left read bus enable |
| l_addr | input | AW | Left word address |
| l_be | input | DW/8 | Left lane enables |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data |
| l_int_n | output | 1 | Left interrupt, active low |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right read bus enable |
| r_addr | input | AW | Right word address |
| r_be | input | DW/8 | Right lane enables |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
A flag that is set or cleared wrongly shows on an interrupt pin one edge after the mailbox access, so each mailbox step is checked right after its edge. Wrong lane masking or a wrong collision winner only shows when the word is read back, which takes one further edge. The bench therefore pairs each write with a read-back and compares the whole word. A read-during-write ordering fault shows as the new word appearing one read too early on the other port.

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [NB-1:0] l_be,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_int_n,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [NB-1:0] r_be,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_int_n
);

  localparam logic [AW-1:0] MB_HI = AW'(DEPTH - 1);
  localparam logic [AW-1:0] MB_LO = AW'(DEPTH - 2);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] l_q, r_q, l_mask, r_mask;
  logic          l_flag, r_flag;

  wire l_wr = l_cs & l_we;
  wire l_rd = l_cs & ~l_we;
  wire r_wr = r_cs & r_we;
  wire r_rd = r_cs & ~r_we;

  wire r_set = l_wr && (l_addr == MB_HI);
  wire r_clr = r_rd && (r_addr == MB_HI);
  wire l_set = r_wr && (r_addr == MB_LO);
  wire l_clr = l_rd && (l_addr == MB_LO);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign l_mask[g*8 +: 8] = {8{l_be[g]}};
    assign r_mask[g*8 +: 8] = {8{r_be[g]}};
  end

  // right side first so the left side overrides on a shared lane
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (r_wr && r_be[b]) mem[r_addr][b*8 +: 8] <= r_wdata[b*8 +: 8];
      if (l_wr && l_be[b]) mem[l_addr][b*8 +: 8] <= l_wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_q    <= '0;
      r_q    <= '0;
      l_flag <= 1'b0;
      r_flag <= 1'b0;
    end else begin
      if (l_rd) l_q <= mem[l_addr] & l_mask;
      if (r_rd) r_q <= mem[r_addr] & r_mask;
      l_flag <= l_set | (l_flag & ~l_clr);
      r_flag <= r_set | (r_flag & ~r_clr);
    end
  end

  assign l_rdata = l_oe ? l_q : '0;
  assign r_rdata = r_oe ? r_q : '0;
  assign l_int_n = ~l_flag;
  assign r_int_n = ~r_flag;

endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_cs,
  input logic          l_we,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_int_n,
  input logic          r_cs,
  input logic          r_we,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_int_n
);
  localparam logic [AW-1:0] HI = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LO = AW'(DEPTH - 2);

  wire to_r_set = l_cs && l_we && l_addr == HI;
  wire to_r_clr = r_cs && !r_we && r_addr == HI;
  wire to_l_set = r_cs && r_we && r_addr == LO;
  wire to_l_clr = l_cs && !l_we && l_addr == LO;

  // R5
  r_int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_r_set |=> !r_int_n);
  // R6
  r_int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_r_clr && !to_r_set) |=> r_int_n);
  // R7
  l_int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_l_set |=> !l_int_n);
  // R8
  l_int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_l_clr && !to_l_set) |=> l_int_n);
  // R12
  r_int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_r_set && !to_r_clr) |=> $stable(r_int_n));
  // R12
  l_int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_l_set && !to_l_clr) |=> $stable(l_int_n));
  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!l_oe -> l_rdata == '0) && (!r_oe -> r_rdata == '0)));
endmodule

bind dpram_mailbox dpram_mailbox_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
  .l_rdata(l_rdata), .l_int_n(l_int_n),
  .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
  .r_rdata(r_rdata), .r_int_n(r_int_n)
);

// File: tb/tb_dpram_mailbox.sv
module tb_dpram_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int DW = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int NB = DW / 8;
  localparam logic [AW-1:0] HI = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LO = AW'(DEPTH - 2);

  logic clk = 0, rst_n = 0;
  logic l_cs, l_we, l_oe, r_cs, r_we, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [NB-1:0] l_be, r_be;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_int_n, r_int_n;
  int checks = 0, fails = 0;
  bit done = 0;

  dpram_mailbox #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_cs = 0; l_we = 0; l_oe = 1; l_addr = '0; l_be = '1; l_wdata = '0;
    r_cs = 0; r_we = 0; r_oe = 1; r_addr = '0; r_be = '1; r_wdata = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic lw(logic [AW-1:0] a, logic [NB-1:0] be, logic [DW-1:0] d);
    l_cs = 1; l_we = 1; l_addr = a; l_be = be; l_wdata = d;
  endtask
  task automatic rw(logic [AW-1:0] a, logic [NB-1:0] be, logic [DW-1:0] d);
    r_cs = 1; r_we = 1; r_addr = a; r_be = be; r_wdata = d;
  endtask
  task automatic lr(logic [AW-1:0] a, logic [NB-1:0] be);
    l_cs = 1; l_we = 0; l_addr = a; l_be = be;
  endtask
  task automatic rr(logic [AW-1:0] a, logic [NB-1:0] be);
    r_cs = 1; r_we = 0; r_addr = a; r_be = be;
  endtask

  task automatic t_reset();
    check("R1 l_int_n", l_int_n, 1);
    check("R1 r_int_n", r_int_n, 1);
    check("R1 l_rdata", l_rdata, 0);
    check("R1 r_rdata", r_rdata, 0);
  endtask

  task automatic t_basic();
    lw(5, 2'b11, 16'hA55A); cyc();
    rr(5, 2'b11); cyc();
    check("R2 right read", r_rdata, 16'hA55A);
    cyc();
    check("R2 held", r_rdata, 16'hA55A);
    lr(5, 2'b11); cyc();
    check("R2 left read", l_rdata, 16'hA55A);
  endtask

  task automatic t_lanes();
    lw(7, 2'b11, 16'h1234); cyc();
    rw(7, 2'b01, 16'hABCD); cyc();
    lr(7, 2'b11); cyc();
    check("R3 lane write", l_rdata, 16'h12CD);
    lr(7, 2'b10); cyc();
    check("R3 lane read", l_rdata, 16'h1200);
  endtask

  task automatic t_oe();
    rr(7, 2'b11); r_oe = 0; cyc();
    r_oe = 0; #1;
    check("R4 oe low", r_rdata, 0);
    r_oe = 1; #1;
    check("R4 oe raised", r_rdata, 16'h12CD);
  endtask

  task automatic t_mail_r();
    lw(HI, 2'b11, 16'hBEEF); cyc();
    check("R5 r_int_n set", r_int_n, 0);
    check("R12 l_int_n untouched", l_int_n, 1);
    lr(HI, 2'b11); cyc();
    check("R12 left read of top", r_int_n, 0);
    check("R2 left reads top", l_rdata, 16'hBEEF);
    rr(HI, 2'b11); cyc();
    check("R6 r_int_n cleared", r_int_n, 1);
    check("R6 message word", r_rdata, 16'hBEEF);
  endtask

  task automatic t_mail_l();
    rw(LO, 2'b11, 16'h0F0F); cyc();
    check("R7 l_int_n set", l_int_n, 0);
    check("R12 r_int_n untouched", r_int_n, 1);
    rr(LO, 2'b11); cyc();
    check("R12 right read of low mbox", l_int_n, 0);
    lw(7, 2'b11, 16'h7777); rr(9, 2'b11); cyc();
    check("R12 other access", l_int_n, 0);
    lr(LO, 2'b11); cyc();
    check("R8 l_int_n cleared", l_int_n, 1);
    check("R8 message word", l_rdata, 16'h0F0F);
  endtask

  task automatic t_setwins();
    lw(HI, 2'b11, 16'h0001); rr(HI, 2'b11); cyc();
    check("R9 set over clear from idle", r_int_n, 0);
    lw(HI, 2'b11, 16'h0002); rr(HI, 2'b11); cyc();
    check("R9 set over clear while set", r_int_n, 0);
    rw(LO, 2'b11, 16'h0003); lr(LO, 2'b11); cyc();
    check("R9 left flag set wins", l_int_n, 0);
    rr(HI, 2'b11); lr(LO, 2'b11); cyc();
    check("R6 clear alone", r_int_n, 1);
    check("R8 clear alone", l_int_n, 1);
  endtask

  task automatic t_collide();
    lw(9, 2'b11, 16'h1111); rw(9, 2'b11, 16'h2222); cyc();
    lr(9, 2'b11); cyc();
    check("R10 left wins", l_rdata, 16'h1111);
    lw(9, 2'b01, 16'h3333); rw(9, 2'b11, 16'h4444); cyc();
    rr(9, 2'b11); cyc();
    check("R10 mixed lanes", r_rdata, 16'h4433);
  endtask

  task automatic t_rdw();
    lw(12, 2'b11, 16'h5555); cyc();
    lw(12, 2'b11, 16'h6666); rr(12, 2'b11); cyc();
    check("R11 old word", r_rdata, 16'h5555);
    rr(12, 2'b11); cyc();
    check("R11 new word next", r_rdata, 16'h6666);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_lanes();
    t_oe();
    t_mail_r();
    t_mail_l();
    t_setwins();
    t_collide();
    t_rdw();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule